// File: doc/BRIEF.md
# Legacy PCI INTx Interrupt Status and Enable Register

This block is one 32-bit control/status word in a PCI host bridge. It takes the four active-low legacy interrupt lines INTA..INTD, brings each through a two-flop synchroniser and latches each as a pending status bit. A per-line enable decides which pending bits reach one registered, combined interrupt output that goes to a parent interrupt controller.

Software reaches the word through a simple write port with per-byte enables and a read port that always shows the current contents. A pending bit is acknowledged by writing one to it. Writing zero leaves it alone, so a read-modify-write of the enables never loses an event. The same word also stores the error-interrupt masks, the error-source enables, the master-priority flags and a TRDY wait value. These are plain storage. The upper 16 bits can be written alone, so a single write of 0xF000 to that half clears every pending bit and disables every line.

Top module: `intx_irq_reg`

## Requirements
- R1: After reset every readable bit is 0 and `irq_o` is 0.
- R2: The INTx inputs are active low (line i: 0=INTA .. 3=INTD). A line driven low at a negedge shows as pending in read bit 28+i after the third following rising edge. It is never visible after only two edges.
- R3: Writing 1 to read bit 28+i with byte enable 3 set clears pending bit i. Writing 0 there leaves the bit unchanged.
- R4: The inputs are level sensitive. If the line is still low, a bit cleared by an acknowledge reads 0 after the acknowledge edge and reads 1 again after the next edge.
- R5: Enable bits 25..22 belong to INTD..INTA (bit 22 = INTA). `irq_o` equals the OR over i of (pending[i] AND enable[i]), delayed by one register stage.
- R6: A pending bit latches whatever its enable is. Setting the enable later raises `irq_o` one edge after that write.
- R7: One write with byte enables 4'b1100 and data 0xF000_0000 clears all four pending bits and all four enables.
- R8: A write changes only the bytes whose byte enable is set. Byte 3 = bits 31..24 and byte 0 = bits 7..0. Without byte enable 3 no pending bit is acknowledged.
- R9: Bit 27 (command-error mask), bit 26 (parity-error mask), bits 21..16 (error-source enables), bits 14..8 (master priority for request lines 6..0) and bits 3..0 (TRDY wait) store the written value and read it back.
- R10: Reserved bits 15 and 7..4 read as 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intx_ni | input | 4 | INTA..INTD bus lines, active low, asynchronous |
| wr_en_i | input | 1 | Write strobe for the word |
| wr_be_i | input | 4 | Byte enables, bit k covers data bits 8k+7..8k |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register contents |
| irq_o | output | 1 | Combined interrupt to the parent controller, active high |

## Verification
An acknowledge write and a set from a line that is still asserted can land on the same pending bit in the same cycle. The bench holds INTA low, acknowledges it and reads the word once right after the acknowledge edge and once after the next edge. It expects 0 and then 1. The bench also writes zero to the status field while an event is pending and while enables change, and checks that the event survives and that `irq_o` follows the new enable one edge later.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned NUM_LINES  = 4;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned STS_LSB    = 28;
  localparam int unsigned CMD_MSK    = 27;
  localparam int unsigned PAR_MSK    = 26;
  localparam int unsigned EN_LSB     = 22;
  localparam int unsigned ERR_LSB    = 16;
  localparam int unsigned ERR_W      = 6;
  localparam int unsigned PRIO_LSB   = 8;
  localparam int unsigned PRIO_W     = 7;
  localparam int unsigned TRDY_LSB   = 0;
  localparam int unsigned TRDY_W     = 4;
endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
  parameter int unsigned LINES  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_ni,
  output logic [LINES-1:0] lvl_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], ~line_ni[i]};
    end
    assign lvl_o[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/intx_status.sv
module intx_status #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] sts_o
);
  logic [LINES-1:0] sts_q;

  // ack cycle wins; a held level re-sets one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q | lvl_i) & ~clr_i;
  end
  assign sts_o = sts_q;

  a_r3_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));
  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((sts_q & $past(clr_i)) == '0));
  a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q | lvl_i)) == '0));
endmodule

// File: rtl/intx_irq_reg.sv
module intx_irq_reg
  import intx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] intx_ni,
  input  logic                 wr_en_i,
  input  logic [3:0]           wr_be_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  output logic [WORD_W-1:0]    rd_data_o,
  output logic                 irq_o
);
  localparam int unsigned BYTES = WORD_W / 8;

  logic [BYTES-1:0]     bw;
  logic [NUM_LINES-1:0] lvl, clr, sts, en_q;
  logic                 cmd_q, par_q, irq_q;
  logic [ERR_W-1:0]     err_q;
  logic [PRIO_W-1:0]    prio_q;
  logic [TRDY_W-1:0]    trdy_q;

  assign bw  = wr_be_i & {BYTES{wr_en_i}};
  assign clr = bw[STS_LSB/8] ? wr_data_i[STS_LSB +: NUM_LINES] : '0;

  intx_sync #(.LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_ni(intx_ni), .lvl_o(lvl));

  intx_status #(.LINES(NUM_LINES)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .clr_i(clr), .sts_o(sts));

  // enables straddle bytes 2 and 3
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_en
    localparam int unsigned POS = EN_LSB + i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            en_q[i] <= 1'b0;
      else if (bw[POS/8])     en_q[i] <= wr_data_i[POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b0;
      par_q  <= 1'b0;
      err_q  <= '0;
      prio_q <= '0;
      trdy_q <= '0;
    end else begin
      if (bw[CMD_MSK/8])  cmd_q  <= wr_data_i[CMD_MSK];
      if (bw[PAR_MSK/8])  par_q  <= wr_data_i[PAR_MSK];
      if (bw[ERR_LSB/8])  err_q  <= wr_data_i[ERR_LSB +: ERR_W];
      if (bw[PRIO_LSB/8]) prio_q <= wr_data_i[PRIO_LSB +: PRIO_W];
      if (bw[TRDY_LSB/8]) trdy_q <= wr_data_i[TRDY_LSB +: TRDY_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts & en_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    rd_data_o[STS_LSB +: NUM_LINES] = sts;
    rd_data_o[CMD_MSK]              = cmd_q;
    rd_data_o[PAR_MSK]              = par_q;
    rd_data_o[EN_LSB +: NUM_LINES]  = en_q;
    rd_data_o[ERR_LSB +: ERR_W]     = err_q;
    rd_data_o[PRIO_LSB +: PRIO_W]   = prio_q;
    rd_data_o[TRDY_LSB +: TRDY_W]   = trdy_q;
  end

  logic unused_rsv;
  assign unused_rsv = ^{wr_data_i[15], wr_data_i[7:4]};

  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts & en_q) == '0) |=> !irq_o);
  a_r5_rise_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(sts & en_q)));
  a_r8_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q) && $stable(prio_q) && $stable(trdy_q) && $stable(err_q));
endmodule

// File: tb/intx_irq_reg_tb_top.sv
module intx_irq_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_n = 4'hF;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_irq_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .intx_ni(intx_n), .wr_en_i(wr_en),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0; wr_data = '0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 word", rd_data, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sync_latency;
    @(negedge clk); intx_n[0] = 1'b0;
    tick(2);
    check("R2 not after two edges", rd_data & 32'hF000_0000, 32'h0);
    tick(1);
    check("R2 INTA pending bit28", rd_data & 32'hF000_0000, 32'h1000_0000);
    check("R6 masked no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_level_reack;
    wr(4'b1000, 32'h1000_0000);
    check("R4 cleared after ack", rd_data & 32'hF000_0000, 32'h0);
    tick(1);
    check("R4 resets while held", rd_data & 32'hF000_0000, 32'h1000_0000);
    intx_n[0] = 1'b1;
    tick(3);
  endtask

  task automatic t_zero_write_and_enable;
    wr(4'b1000, 32'h0000_0000);
    check("R3 zero write keeps", rd_data & 32'hF000_0000, 32'h1000_0000);
    wr(4'b0100, 32'h0040_0000);
    check("R6 enable read", rd_data, 32'h1040_0000);
    check("R6 irq not yet", {31'b0, irq}, 32'h0);
    tick(1);
    check("R5 irq after enable", {31'b0, irq}, 32'h1);
    wr(4'b1000, 32'h1000_0000);
    check("R3 ack clears", rd_data & 32'hF000_0000, 32'h0);
    check("R5 irq lags", {31'b0, irq}, 32'h1);
    tick(1);
    check("R5 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_intd_masked;
    @(negedge clk); intx_n[3] = 1'b0;
    tick(4);
    intx_n[3] = 1'b1;
    check("R2 INTD bit31", rd_data & 32'hF000_0000, 32'h8000_0000);
    check("R5 INTD disabled", {31'b0, irq}, 32'h0);
    wr(4'b1000, 32'h0200_0000);
    tick(1);
    check("R5 INTD enabled irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_bytes;
    wr(4'b0111, 32'hFFFF_FFFF);
    check("R8 no ack w/o byte3, R10 R9", rd_data, 32'h82FF_7F0F);
    wr(4'b0001, 32'h0000_0005);
    check("R8 byte0 only", rd_data, 32'h82FF_7F05);
    wr(4'b1111, 32'hFFFF_FFFF);
    check("R9 R10 full write", rd_data, 32'h0FFF_7F0F);
    wr(4'b1111, 32'h0A95_2A0A);
    check("R9 pattern", rd_data, 32'h0A95_2A0A);
  endtask

  task automatic t_upper_clear;
    wr(4'b1111, 32'h0FC0_0000);
    @(negedge clk); intx_n = 4'h0;
    tick(4);
    intx_n = 4'hF;
    check("R7 before", rd_data, 32'hFFC0_0000);
    check("R7 irq before", {31'b0, irq}, 32'h1);
    wr(4'b1100, 32'hF000_0000);
    check("R7 all cleared", rd_data, 32'h0);
    tick(1);
    check("R7 irq off", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    tick(2);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_sync_latency();
    t_level_reack();
    t_zero_write_and_enable();
    t_intd_masked();
    t_bytes();
    t_upper_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule